// File: doc/BRIEF.md
# Host Request and Acknowledge Controller

This block sits between a host-port register file and the host-facing pins. It works out when the device needs service from the host. It drives the shared, wire-ORed request line and interprets the single acknowledge pin. In interrupt mode the request follows the transmit-empty and receive-full flags, each gated by its own enable bit. When a request is pending, an acknowledge fetches the interrupt vector byte onto the host data bus. In the two DMA modes the request follows one flag alone. The acknowledge pin then becomes the transfer strobe, and the address, enable and direction pins play no part.

The DMA data path is reduced to one register. In a host-read transfer, the outbound byte is placed on the bus while acknowledge is held. A one-cycle pulse then tells the register file to clear its receive-full flag. In a host-write transfer, the inbound byte is captured, and a one-cycle pulse clears the transmit-empty flag. The request pin is modelled as an output enable that pulls the line low, and it can be switched to a push-pull general-purpose level.

Top module: `hrq_ctrl`

## Requirements
- R1: With mode 2'b00, `hreq_status` in the cycle after a clock edge equals (txde AND tx_mask) OR (rxdf AND rx_mask), as sampled at that edge.
- R2: With mode 2'b01 the request follows rxdf alone, and with mode 2'b10 it follows txde alone; in both cases the mask bits have no effect.
- R3: In modes 2'b01 and 2'b10, an acknowledge (ack_n low) sampled at an edge forces `hreq_status` low after that edge, whatever the flags are.
- R4: While rst_n is low at an edge, every output is cleared after that edge (request, bus enable, pulses, captured data), and the vector byte returns to 8'h0F.
- R5: With mode 2'b00, `bus_oe` is high and `bus_out` carries the vector byte exactly while `hreq_status` is high and ack_n is low; an acknowledge without a pending request leaves the bus released and `bus_out` at zero.
- R6: During a vector fetch, a write to the vector byte is ignored. In mode 2'b00, an acknowledge produces no DMA pulse.
- R7: In a DMA mode, each high-to-low step of ack_n gives exactly one one-cycle pulse, in the cycle after the first edge that samples ack_n low. Mode 2'b01 gives `dma_rd_pulse`. Mode 2'b10 gives `dma_wr_pulse` and captures `bus_in` into `dma_wdata` at that same edge.
- R8: With mode 2'b01 and ack_n low, `bus_oe` is high and `bus_out` equals `dma_rdata`.
- R9: With gpio_en low, `hreq_pin_oe` equals `hreq_status` and `hreq_pin_o` is 0 (open drain). With gpio_en high, `hreq_pin_oe` is 1 and `hreq_pin_o` equals gpio_level.
- R10: With mode 2'b11, no request is raised and an acknowledge produces neither a pulse nor a bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hm_mode | input | 2 | Service mode: 00 interrupt, 01 DMA host-read, 10 DMA host-write, 11 reserved |
| txde | input | 1 | Transmit register empty flag |
| rxdf | input | 1 | Receive register full flag |
| tx_mask | input | 1 | Enable for the transmit-empty request in interrupt mode |
| rx_mask | input | 1 | Enable for the receive-full request in interrupt mode |
| ack_n | input | 1 | Acknowledge pin, active low |
| ivr_we | input | 1 | Write strobe for the vector byte |
| ivr_wdata | input | 8 | New vector byte |
| dma_rdata | input | 8 | Outbound byte for a host-read DMA transfer |
| bus_in | input | 8 | Host data bus input |
| gpio_en | input | 1 | Switch the request pin to push-pull general-purpose use |
| gpio_level | input | 1 | Level driven in general-purpose use |
| hreq_pin_oe | output | 1 | Request pin output enable |
| hreq_pin_o | output | 1 | Request pin output value |
| hreq_status | output | 1 | Registered request state, readable by the host |
| bus_oe | output | 1 | Host data bus drive enable |
| bus_out | output | 8 | Host data bus output value |
| dma_rd_pulse | output | 1 | One-cycle pulse that clears the receive-full flag |
| dma_wr_pulse | output | 1 | One-cycle pulse that clears the transmit-empty flag |
| dma_wdata | output | 8 | Byte captured in a host-write DMA transfer |

## Verification
In interrupt mode the request is swept over all sixteen combinations of the two flags and two masks, which separates the flag-and-mask terms from each other. The same flags are then applied in each DMA mode and in the reserved mode, to show that the masks drop out and that each mode selects only its own flag. Acknowledge is held for several cycles, both with and without a pending request, which separates the vector fetch from an idle strobe. It also shows whether a pulse comes from the edge or from the level of the acknowledge. Changing bus bytes between DMA write transfers shows that the capture happens at the strobe edge and at no other time.

// File: rtl/hrq_pkg.sv
// Shared types for the host request controller.
// Assumes a two-bit service mode field decoded as below.
package hrq_pkg;
    typedef enum logic [1:0] {
        HM_IRQ    = 2'b00,
        HM_DMA_RD = 2'b01,
        HM_DMA_WR = 2'b10,
        HM_RSVD   = 2'b11
    } hrq_mode_e;
endpackage

// File: rtl/hrq_req_eval.sv
// Works out the request source for the current mode and registers it.
// Assumes the flags are synchronous to clk and that ack is already active high.
module hrq_req_eval
    import hrq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hrq_mode_e mode,
    input  logic      txde,
    input  logic      rxdf,
    input  logic      tx_mask,
    input  logic      rx_mask,
    input  logic      ack,
    output logic      hreq_q
);
    logic src;
    logic dma_mode;

    // Select the flag that can raise a request in each mode.
    always_comb begin
        unique case (mode)
            HM_IRQ:    src = (txde & tx_mask) | (rxdf & rx_mask);
            HM_DMA_RD: src = rxdf;
            HM_DMA_WR: src = txde;
            default:   src = 1'b0;
        endcase
        dma_mode = (mode != HM_IRQ);
    end

    // Register the request; a DMA acknowledge withdraws it.
    always_ff @(posedge clk) begin
        if (!rst_n) hreq_q <= 1'b0;
        else        hreq_q <= src & ~(dma_mode & ack);
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_IRQ && ((txde && tx_mask) || (rxdf && rx_mask))) |=> hreq_q); // R1
    AST_DMA_RD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_DMA_RD && rxdf && !ack) |=> hreq_q); // R2
    AST_DMA_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != HM_IRQ && ack) |=> !hreq_q); // R3
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_RSVD) |=> !hreq_q); // R10
endmodule

// File: rtl/hrq_ivr.sv
// Holds the interrupt vector byte. A write is refused while a fetch is in progress.
// Assumes the write strobe lasts one cycle per write.
module hrq_ivr #(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] RST_VAL = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              block,
    output logic [DATA_W-1:0] ivr_q
);
    // Load a new vector byte unless a fetch has frozen the state.
    always_ff @(posedge clk) begin
        if (!rst_n)            ivr_q <= RST_VAL;
        else if (we && !block) ivr_q <= wdata;
    end

    AST_IVR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> $stable(ivr_q)); // R6
endmodule

// File: rtl/hrq_ack_ctrl.sv
// Interprets the acknowledge pin: vector fetch in interrupt mode, data strobe in DMA modes.
// Assumes ack is synchronous to clk; one pulse is made per acknowledge assertion.
module hrq_ack_ctrl
    import hrq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hrq_mode_e         mode,
    input  logic              ack,
    input  logic              hreq_q,
    input  logic [DATA_W-1:0] ivr,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic              vec_fetch,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_out,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] wdata_q
);
    logic ack_d;
    logic ack_rise;

    // Decode the fetch window, the edge of the strobe, and the bus source.
    always_comb begin
        vec_fetch = (mode == HM_IRQ) & hreq_q & ack;
        ack_rise  = ack & ~ack_d;
        bus_oe    = vec_fetch | ((mode == HM_DMA_RD) & ack);
        if (!bus_oe)           bus_out = '0;
        else if (vec_fetch)    bus_out = ivr;
        else                   bus_out = dma_rdata;
    end

    // Remember the previous acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_d <= 1'b0;
        else        ack_d <= ack;
    end

    // Produce one-cycle clear pulses and capture host-write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pulse <= 1'b0;
            wr_pulse <= 1'b0;
            wdata_q  <= '0;
        end else begin
            rd_pulse <= ack_rise & (mode == HM_DMA_RD);
            wr_pulse <= ack_rise & (mode == HM_DMA_WR);
            if (ack_rise && mode == HM_DMA_WR) wdata_q <= bus_in;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse || wr_pulse) |=> !(rd_pulse || wr_pulse)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pulse && wr_pulse)); // R7
    AST_NO_IRQ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_IRQ || mode == HM_RSVD) |=> !(rd_pulse || wr_pulse)); // R6
endmodule

// File: rtl/hrq_pin_drv.sv
// Drives the request pin: open drain when serving the host, push-pull in general-purpose use.
// Assumes an external pull-up on the shared line.
module hrq_pin_drv (
    input  logic gpio_en,
    input  logic gpio_level,
    input  logic hreq_q,
    output logic pin_oe,
    output logic pin_o
);
    // Pull the line low for a request, or drive the chosen general-purpose level.
    always_comb begin
        pin_oe = gpio_en ? 1'b1 : hreq_q;
        pin_o  = gpio_en ? gpio_level : 1'b0;
        if (!gpio_en) begin
            AST_OD_LOW: assert (pin_o == 1'b0); // R9
        end
    end
endmodule

// File: rtl/hrq_ctrl.sv
// Top level of the host request and acknowledge controller.
// Assumes all inputs are synchronous to clk; the acknowledge pin is active low.
module hrq_ctrl
    import hrq_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] IVR_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hm_mode,
    input  logic              txde,
    input  logic              rxdf,
    input  logic              tx_mask,
    input  logic              rx_mask,
    input  logic              ack_n,
    input  logic              ivr_we,
    input  logic [DATA_W-1:0] ivr_wdata,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              gpio_en,
    input  logic              gpio_level,
    output logic              hreq_pin_oe,
    output logic              hreq_pin_o,
    output logic              hreq_status,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_out,
    output logic              dma_rd_pulse,
    output logic              dma_wr_pulse,
    output logic [DATA_W-1:0] dma_wdata
);
    hrq_mode_e         mode;
    logic              ack;
    logic              hreq_q;
    logic              vec_fetch;
    logic [DATA_W-1:0] ivr_q;

    // Convert the pin-level inputs to internal form.
    always_comb begin
        mode = hrq_mode_e'(hm_mode);
        ack  = ~ack_n;
    end

    hrq_req_eval u_req (
        .clk(clk), .rst_n(rst_n), .mode(mode), .txde(txde), .rxdf(rxdf),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .ack(ack), .hreq_q(hreq_q)
    );

    hrq_ivr #(.DATA_W(DATA_W), .RST_VAL(IVR_RST)) u_ivr (
        .clk(clk), .rst_n(rst_n), .we(ivr_we), .wdata(ivr_wdata),
        .block(vec_fetch), .ivr_q(ivr_q)
    );

    hrq_ack_ctrl #(.DATA_W(DATA_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ack(ack), .hreq_q(hreq_q),
        .ivr(ivr_q), .dma_rdata(dma_rdata), .bus_in(bus_in),
        .vec_fetch(vec_fetch), .bus_oe(bus_oe), .bus_out(bus_out),
        .rd_pulse(dma_rd_pulse), .wr_pulse(dma_wr_pulse), .wdata_q(dma_wdata)
    );

    hrq_pin_drv u_pin (
        .gpio_en(gpio_en), .gpio_level(gpio_level), .hreq_q(hreq_q),
        .pin_oe(hreq_pin_oe), .pin_o(hreq_pin_o)
    );

    assign hreq_status = hreq_q;
endmodule

// File: tb/hrq_ctrl_bench.sv
module hrq_ctrl_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] hm_mode;
    logic       txde, rxdf, tx_mask, rx_mask, ack_n, ivr_we, gpio_en, gpio_level;
    logic [7:0] ivr_wdata, dma_rdata, bus_in;
    logic       hreq_pin_oe, hreq_pin_o, hreq_status, bus_oe, dma_rd_pulse, dma_wr_pulse;
    logic [7:0] bus_out, dma_wdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit cmp_on = 1'b0;

    // Behavioural reference state
    bit       m_hreq, m_ack_prev, m_rd, m_wr;
    bit [7:0] m_ivr, m_wdata;

    always #(CLK_P/2) clk = ~clk;

    hrq_ctrl u_hrq_ctrl (
        .clk(clk), .rst_n(rst_n), .hm_mode(hm_mode), .txde(txde), .rxdf(rxdf),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .ack_n(ack_n), .ivr_we(ivr_we),
        .ivr_wdata(ivr_wdata), .dma_rdata(dma_rdata), .bus_in(bus_in),
        .gpio_en(gpio_en), .gpio_level(gpio_level), .hreq_pin_oe(hreq_pin_oe),
        .hreq_pin_o(hreq_pin_o), .hreq_status(hreq_status), .bus_oe(bus_oe),
        .bus_out(bus_out), .dma_rd_pulse(dma_rd_pulse), .dma_wr_pulse(dma_wr_pulse),
        .dma_wdata(dma_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Reference model update at each edge
    always @(posedge clk) begin
        bit ack, src, fetch, rise;
        ack = !ack_n;
        case (hm_mode)
            2'd0:    src = (txde && tx_mask) || (rxdf && rx_mask);
            2'd1:    src = rxdf;
            2'd2:    src = txde;
            default: src = 1'b0;
        endcase
        fetch = (hm_mode == 2'd0) && m_hreq && ack;
        if (!rst_n) begin
            m_hreq = 0; m_ack_prev = 0; m_rd = 0; m_wr = 0; m_ivr = 8'h0F; m_wdata = 0;
        end else begin
            if (ivr_we && !fetch) m_ivr = ivr_wdata;
            rise = ack && !m_ack_prev;
            m_rd = rise && hm_mode == 2'd1;
            m_wr = rise && hm_mode == 2'd2;
            if (m_wr) m_wdata = bus_in;
            m_hreq = src && !(hm_mode != 2'd0 && ack);
            m_ack_prev = ack;
        end
    end

    // Compare every output against the model on every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            bit ack, eoe;
            bit [7:0] eout;
            ack  = !ack_n;
            eoe  = (hm_mode == 2'd0 && m_hreq && ack) || (hm_mode == 2'd1 && ack);
            eout = !eoe ? 8'h00 : (hm_mode == 2'd0 ? m_ivr : dma_rdata);
            chk("R1 R2 R3 R10 model hreq_status", hreq_status, m_hreq);
            chk("R9 model pin_oe", hreq_pin_oe, gpio_en ? 1'b1 : m_hreq);
            chk("R9 model pin_o", hreq_pin_o, gpio_en ? gpio_level : 1'b0);
            chk("R5 R8 model bus_oe", bus_oe, eoe);
            chk("R5 R6 R8 model bus_out", bus_out, eout);
            chk("R7 model rd_pulse", dma_rd_pulse, m_rd);
            chk("R7 model wr_pulse", dma_wr_pulse, m_wr);
            chk("R7 model dma_wdata", dma_wdata, m_wdata);
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; hm_mode = 0; txde = 0; rxdf = 0; tx_mask = 0; rx_mask = 0;
        ack_n = 1; ivr_we = 0; ivr_wdata = 0; dma_rdata = 0; bus_in = 0;
        gpio_en = 0; gpio_level = 0;
        repeat (3) tick();
        cmp_on = 1;
        @(negedge clk);
        chk("R4 reset hreq_status", hreq_status, 0);
        chk("R4 reset bus_oe", bus_oe, 0);
        chk("R4 reset pulses", {dma_rd_pulse, dma_wr_pulse}, 0);
        chk("R4 reset dma_wdata", dma_wdata, 0);
        tick(); rst_n = 1;

        // R1: sweep flags and masks in interrupt mode
        for (int k = 0; k < 16; k++) begin
            {txde, rxdf, tx_mask, rx_mask} = 4'(k);
            tick();
            @(negedge clk);
            chk("R1 sweep hreq_status", hreq_status,
                ((k >> 3) & (k >> 1) & 1) | ((k >> 2) & k & 1));
        end

        // R4 R5: first fetch shows reset vector
        txde = 1; rxdf = 0; tx_mask = 1; rx_mask = 0;
        tick(); tick(); ack_n = 0;
        @(negedge clk);
        chk("R4 R5 fetch reset vector", {bus_oe, bus_out}, {1'b1, 8'h0F});
        // R6: write during fetch is refused
        ivr_we = 1; ivr_wdata = 8'h3C;
        tick(); ivr_we = 0; ack_n = 1;
        tick(); ack_n = 0;
        @(negedge clk);
        chk("R6 vector unchanged after write during fetch", bus_out, 8'h0F);
        chk("R6 no strobe in interrupt mode", {dma_rd_pulse, dma_wr_pulse}, 0);
        tick(); ack_n = 1; ivr_we = 1; ivr_wdata = 8'hA5;
        tick(); ivr_we = 0; ack_n = 0;
        @(negedge clk);
        chk("R5 fetch new vector", bus_out, 8'hA5);
        // R5: acknowledge without pending request
        tick(); ack_n = 1; txde = 0;
        tick(); tick(); ack_n = 0;
        @(negedge clk);
        chk("R5 no drive without request", {bus_oe, bus_out}, 9'h0);
        tick(); ack_n = 1;

        // R2 R3 R7 R8: host-read DMA
        hm_mode = 2'd1; rxdf = 1; rx_mask = 0; tx_mask = 0; dma_rdata = 8'h5A;
        tick(); tick();
        @(negedge clk);
        chk("R2 read DMA request ignores mask", hreq_status, 1);
        tick(); ack_n = 0;
        @(negedge clk);
        chk("R8 read DMA bus drive", {bus_oe, bus_out}, {1'b1, 8'h5A});
        tick();
        @(negedge clk);
        chk("R7 read pulse", dma_rd_pulse, 1);
        chk("R3 ack withdraws request", hreq_status, 0);
        tick(); tick();
        @(negedge clk);
        chk("R7 single pulse while held", dma_rd_pulse, 0);
        ack_n = 1;
        repeat (2) tick();

        // R2 R7: host-write DMA, two transfers
        hm_mode = 2'd2; rxdf = 0; txde = 1; bus_in = 8'hC3;
        tick(); tick();
        @(negedge clk);
        chk("R2 write DMA request", hreq_status, 1);
        tick(); ack_n = 0;
        tick(); bus_in = 8'h11;
        @(negedge clk);
        chk("R7 write pulse and capture", {dma_wr_pulse, dma_wdata}, {1'b1, 8'hC3});
        tick(); ack_n = 1; bus_in = 8'h96;
        tick(); ack_n = 0;
        tick(); ack_n = 1;
        @(negedge clk);
        chk("R7 second capture", dma_wdata, 8'h96);
        repeat (2) tick();

        // R10: reserved mode
        hm_mode = 2'd3; txde = 1; rxdf = 1; tx_mask = 1; rx_mask = 1;
        tick(); tick(); ack_n = 0;
        tick();
        @(negedge clk);
        chk("R10 no request", hreq_status, 0);
        chk("R10 no pulse or drive", {dma_rd_pulse, dma_wr_pulse, bus_oe}, 0);
        tick(); ack_n = 1;

        // R9: pin driver
        hm_mode = 2'd0; gpio_en = 1; gpio_level = 1;
        tick(); tick();
        @(negedge clk);
        chk("R9 gpio high", {hreq_pin_oe, hreq_pin_o}, 2'b11);
        tick(); gpio_level = 0;
        @(negedge clk);
        chk("R9 gpio low", {hreq_pin_oe, hreq_pin_o}, 2'b10);
        tick(); gpio_en = 0;
        @(negedge clk);
        chk("R9 open drain pull", {hreq_pin_oe, hreq_pin_o}, 2'b10);

        // R4: reset in mid operation
        tick(); rst_n = 0;
        tick(); rst_n = 1;
        @(negedge clk);
        chk("R4 mid reset hreq_status", hreq_status, 0);
        tick(); tick(); ack_n = 0;
        @(negedge clk);
        chk("R4 vector restored", bus_out, 8'h0F);
        tick(); ack_n = 1;
        tick();

        done = 1;
        summary();
        $finish;
    end
endmodule